// File: doc/BRIEF.md
# Epoch-Ordered Out-of-Order Integrity-Tree Update Scheduler

This block decides which persists may hash their next integrity-tree node under epoch persistency. Persists are allocated in order into a circular persist table, and each is tagged with the epoch that is open at that moment. A fence closes the open epoch. Each epoch-table entry records an epoch number, its valid, closed and non-empty flags, the tree level it has been granted, and first and one-past-last indices into the persist table. Tree levels run from the leaf level `LEVELS` up to the root at level 1.

Inside an epoch, every persist sitting at the granted level is authorized on `pt_go`. The hash engine reports a finished node on `node_done_*`. Each persist then moves up on its own, independently of its siblings. A persist that has finished the granted level stalls until its epoch is granted the next level.

Across epochs, a three-state scheduler hands out levels in epoch order:

- **IDLE**: there is no closed epoch.
  - IDLE -> TRACK when any epoch is closed.
- **TRACK**: waits until every closed epoch has finished its granted level.
  - TRACK -> IDLE when no closed epoch remains.
  - TRACK -> ADVANCE when all closed epochs are ready.
- **ADVANCE**: lasts one cycle and always returns to TRACK. In that cycle:
  - every closed epoch moves one level toward the root;
  - a younger epoch holds its level rather than land on the level of the epoch ahead of it;
  - the oldest epoch is retired and reported on `epoch_done_*` if it has just finished the root or has no persists.

Top module: `epoch_ooo_sched`

## Requirements
- R1: After reset, `pt_go` is all zero, `persist_done_valid` and `epoch_done_valid` are low, and both `alloc_ready` and `fence_ready` are high.
- R2: Accepted allocations take consecutive persist-table indices starting at 0, wrapping from `PT_DEPTH-1` to 0. `alloc_idx` and `alloc_eid` show the index and epoch number before acceptance. Epoch numbers are issued from a counter that starts at 0 and increases by one for each new epoch. An allocation while no epoch is open starts a new epoch.
- R3: A persist of the open (not yet fenced) epoch is never authorized. After its fence, the epoch's persists are authorized at leaf level `LEVELS`.
- R4: Within an epoch, a `node_done` for an authorized persist clears that persist's `pt_go` bit in the next cycle. It leaves the other persists of the epoch authorized.
- R5: A persist that has finished its epoch's granted level keeps `pt_go` low until the grant moves. Grants move only when every persist of every closed epoch has finished its epoch's granted level.
- R6: No two closed epochs hold the same granted level. A younger epoch is granted the level just below the older one while the older works higher up the tree (pipelined).
- R7: A `node_done` for an authorized persist at level 1 produces a one-cycle `persist_done_valid` pulse with that index in the next cycle.
- R8: Epochs are retired in the order they were opened. Each retirement is a one-cycle `epoch_done_valid` pulse carrying the epoch number, produced only after all its persists have finished level 1.
- R9: While `NUM_EPOCHS` entries are in use and none is open, `fence_ready` and `alloc_ready` are low. A refused fence or allocation changes nothing, and no epoch number is consumed.
- R10: A fence while no epoch is open creates an empty closed epoch. It is retired without any `node_done`.
- R11: A `node_done` naming a persist that is not authorized is ignored: its level does not change.
- R12: With `PT_DEPTH` persists in flight, `alloc_ready` is low and a fence is still accepted. Retiring the epoch frees all of them, and the next allocation index continues the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate one persist |
| alloc_ready | output | 1 | Allocation will be accepted this cycle |
| alloc_idx | output | PT_W | Persist-table index the next allocation receives |
| alloc_eid | output | EID_W | Epoch number the next allocation is tagged with |
| fence_valid | input | 1 | Epoch boundary request |
| fence_ready | output | 1 | Fence will be accepted this cycle |
| node_done_valid | input | 1 | Hash engine finished one node |
| node_done_idx | input | PT_W | Persist whose node finished |
| pt_go | output | PT_DEPTH | Per-persist authorization to hash its current level |
| persist_done_valid | output | 1 | A persist finished the root |
| persist_done_idx | output | PT_W | Index of that persist |
| epoch_done_valid | output | 1 | An epoch retired |
| epoch_done_eid | output | EID_W | Number of the retired epoch |

## Verification
The bench finishes one persist of an epoch before its sibling. A design that couples siblings would drop both authorizations or keep the finished one. It closes two epochs at once and checks that the younger waits at the leaf until the older leaves it. A design without the hold rule would grant both the same level.

It also exercises several other corner cases, each with the failure it exposes:

| Scenario | What a wrong design would do |
|---|---|
| Fence is refused while the table is full | Consume an epoch number |
| Empty epoch is fenced | Never retire it |
| `node_done` is sent for an unauthorized persist | Finish the root one node early |
| 64 persists fill one epoch | Treat equal first and last indices as an empty epoch and retire it too soon |

// File: rtl/eps_pkg.sv
package eps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRACK,
        ST_ADVANCE
    } sched_state_t;

    // Circular membership of index i in [first, last); has marks a non-empty range,
    // so first == last with has set means the whole table.
    function automatic logic in_range(input int i, input int first, input int last, input logic has);
        if (!has) return 1'b0;
        if (first < last) return (i >= first) && (i < last);
        return (i >= first) || (i < last);
    endfunction

endpackage

// File: rtl/eps_level_fsm.sv
module eps_level_fsm
    import eps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_closed,
    input  logic all_ready,
    output logic step
);

    sched_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_closed) state_d = ST_TRACK;
            ST_TRACK: begin
                if (!any_closed)    state_d = ST_IDLE;
                else if (all_ready) state_d = ST_ADVANCE;
            end
            ST_ADVANCE: state_d = ST_TRACK;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step = (state_q == ST_ADVANCE);
    end

    assert_step_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADVANCE) |-> $past(all_ready && any_closed));

endmodule

// File: rtl/eps_persist_table.sv
module eps_persist_table
    import eps_pkg::*;
#(
    parameter int NUM_EPOCHS = 2,
    parameter int PT_DEPTH   = 64,
    parameter int LEVELS     = 4,
    parameter int PT_W       = 6,
    parameter int LVL_W      = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 alloc_fire,
    input  logic [PT_W-1:0]                      alloc_idx,
    input  logic                                 done_valid,
    input  logic [PT_W-1:0]                      done_idx,
    input  logic [NUM_EPOCHS-1:0]                ep_valid,
    input  logic [NUM_EPOCHS-1:0]                ep_has,
    input  logic [NUM_EPOCHS-1:0][PT_W-1:0]      ep_first,
    input  logic [NUM_EPOCHS-1:0][PT_W-1:0]      ep_last,
    input  logic [NUM_EPOCHS-1:0][LVL_W-1:0]     ep_grant,
    output logic [PT_DEPTH-1:0]                  go,
    output logic [NUM_EPOCHS-1:0]                ep_busy,
    output logic                                 persist_done_valid,
    output logic [PT_W-1:0]                      persist_done_idx
);

    // next level each persist must update; 0 once past the root
    logic [LVL_W-1:0] lvl_q [PT_DEPTH];
    logic             accept;

    always_comb begin
        go      = '0;
        ep_busy = '0;
        for (int i = 0; i < PT_DEPTH; i++) begin
            for (int e = 0; e < NUM_EPOCHS; e++) begin
                if (ep_valid[e] && in_range(i, int'(ep_first[e]), int'(ep_last[e]), ep_has[e])) begin
                    if (lvl_q[i] == ep_grant[e]) go[i] = 1'b1;
                    if (lvl_q[i] >= ep_grant[e]) ep_busy[e] = 1'b1;
                end
            end
        end
    end

    assign accept = done_valid && go[done_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_DEPTH; i++) lvl_q[i] <= '0;
            persist_done_valid <= 1'b0;
            persist_done_idx   <= '0;
        end else begin
            if (alloc_fire) lvl_q[alloc_idx] <= LVL_W'(LEVELS);
            if (accept)     lvl_q[done_idx]  <= lvl_q[done_idx] - LVL_W'(1);
            persist_done_valid <= accept && (lvl_q[done_idx] == LVL_W'(1));
            persist_done_idx   <= done_idx;
        end
    end

    assert_root_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && go[done_idx] && lvl_q[done_idx] == LVL_W'(1)) |=> persist_done_valid);

    assert_unauth_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !go[done_idx]) |=> !persist_done_valid);

endmodule

// File: rtl/eps_epoch_table.sv
module eps_epoch_table #(
    parameter int NUM_EPOCHS = 2,
    parameter int PT_DEPTH   = 64,
    parameter int LEVELS     = 4,
    parameter int EID_W      = 6,
    parameter int PT_W       = 6,
    parameter int LVL_W      = 3,
    parameter int EP_W       = 1,
    parameter int CNT_W      = 2,
    parameter int PCNT_W     = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_valid,
    input  logic                             fence_valid,
    input  logic                             step,
    input  logic [NUM_EPOCHS-1:0]            ep_busy,
    output logic                             alloc_ready,
    output logic                             alloc_fire,
    output logic [PT_W-1:0]                  alloc_idx,
    output logic [EID_W-1:0]                 alloc_eid,
    output logic                             fence_ready,
    output logic [NUM_EPOCHS-1:0]            ep_valid,
    output logic [NUM_EPOCHS-1:0]            ep_has,
    output logic [NUM_EPOCHS-1:0][PT_W-1:0]  ep_first,
    output logic [NUM_EPOCHS-1:0][PT_W-1:0]  ep_last,
    output logic [NUM_EPOCHS-1:0][LVL_W-1:0] ep_grant,
    output logic                             any_closed,
    output logic                             all_ready,
    output logic                             epoch_done_valid,
    output logic [EID_W-1:0]                 epoch_done_eid
);

    localparam logic [LVL_W-1:0] UNGRANTED = LVL_W'(LEVELS + 1);

    logic [NUM_EPOCHS-1:0]             v_q, closed_q, has_q;
    logic [NUM_EPOCHS-1:0][EID_W-1:0]  eid_q;
    logic [NUM_EPOCHS-1:0][PT_W-1:0]   first_q, last_q;
    logic [NUM_EPOCHS-1:0][LVL_W-1:0]  grant_q, grant_nx;
    logic [EP_W-1:0]                   head_q, youngest, new_slot, e_c;
    logic [CNT_W-1:0]                  cnt_q;
    logic [EID_W-1:0]                  gctr_q;
    logic [PT_W-1:0]                   tail_q, span;
    logic [PCNT_W-1:0]                 used_q, freed;
    logic                              open_exists, room, fence_fire, retire, create;
    logic                              prev_live;
    logic [LVL_W-1:0]                  prev_g, cand;

    assign youngest    = head_q + EP_W'(cnt_q - CNT_W'(1));
    assign new_slot    = head_q + EP_W'(cnt_q);
    assign open_exists = (cnt_q != '0) && v_q[youngest] && !closed_q[youngest];
    assign room        = (cnt_q < CNT_W'(NUM_EPOCHS));
    assign alloc_ready = (used_q < PCNT_W'(PT_DEPTH)) && (open_exists || room);
    assign fence_ready = open_exists || room;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign fence_fire  = fence_valid && fence_ready;
    assign create      = !open_exists && (alloc_fire || fence_fire);
    assign alloc_idx   = tail_q;
    assign alloc_eid   = open_exists ? eid_q[youngest] : gctr_q;

    assign ep_valid = v_q;
    assign ep_has   = has_q;
    assign ep_first = first_q;
    assign ep_last  = last_q;
    assign ep_grant = grant_q;

    always_comb begin
        any_closed = 1'b0;
        all_ready  = 1'b1;
        for (int e = 0; e < NUM_EPOCHS; e++) begin
            if (v_q[e] && closed_q[e]) begin
                any_closed = 1'b1;
                if (ep_busy[e]) all_ready = 1'b0;
            end
        end
    end

    // level hand-off, walked from the oldest entry toward the youngest
    always_comb begin
        grant_nx  = grant_q;
        retire    = 1'b0;
        prev_live = 1'b0;
        prev_g    = '0;
        cand      = '0;
        e_c       = '0;
        for (int k = 0; k < NUM_EPOCHS; k++) begin
            e_c = EP_W'(int'(head_q) + k);
            if (k < int'(cnt_q) && v_q[e_c] && closed_q[e_c]) begin
                if (k == 0 && (grant_q[e_c] == LVL_W'(1) || !has_q[e_c])) begin
                    retire = 1'b1;
                end else begin
                    cand = grant_q[e_c] - LVL_W'(1);
                    if (prev_live && cand <= prev_g) cand = grant_q[e_c];
                    grant_nx[e_c] = cand;
                    prev_g        = cand;
                    prev_live     = 1'b1;
                end
            end
        end
    end

    assign span  = last_q[head_q] - first_q[head_q];
    assign freed = !has_q[head_q] ? '0 : (span == '0) ? PCNT_W'(PT_DEPTH) : PCNT_W'(span);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0; closed_q <= '0; has_q <= '0;
            eid_q <= '0; first_q <= '0; last_q <= '0; grant_q <= '0;
            head_q <= '0; cnt_q <= '0; gctr_q <= '0; tail_q <= '0; used_q <= '0;
            epoch_done_valid <= 1'b0;
            epoch_done_eid   <= '0;
        end else begin
            epoch_done_valid <= 1'b0;
            if (step) begin
                grant_q <= grant_nx;
                if (retire) begin
                    v_q[head_q]      <= 1'b0;
                    head_q           <= head_q + EP_W'(1);
                    epoch_done_valid <= 1'b1;
                    epoch_done_eid   <= eid_q[head_q];
                end
            end
            if (open_exists) begin
                if (alloc_fire) begin
                    last_q[youngest] <= last_q[youngest] + PT_W'(1);
                    has_q[youngest]  <= 1'b1;
                end
                if (fence_fire) closed_q[youngest] <= 1'b1;
            end else if (create) begin
                v_q[new_slot]      <= 1'b1;
                closed_q[new_slot] <= fence_fire;
                has_q[new_slot]    <= alloc_fire;
                eid_q[new_slot]    <= gctr_q;
                first_q[new_slot]  <= tail_q;
                last_q[new_slot]   <= tail_q + PT_W'(alloc_fire);
                grant_q[new_slot]  <= UNGRANTED;
                gctr_q             <= gctr_q + EID_W'(1);
            end
            cnt_q  <= cnt_q + CNT_W'(create) - CNT_W'(step && retire);
            tail_q <= tail_q + PT_W'(alloc_fire);
            used_q <= used_q + PCNT_W'(alloc_fire) - ((step && retire) ? freed : '0);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NUM_EPOCHS));

    for (genvar a = 0; a < NUM_EPOCHS; a++) begin : g_ent
        assert_open_ungranted_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q[a] && !closed_q[a]) |-> (grant_q[a] == UNGRANTED));
        for (genvar b = a + 1; b < NUM_EPOCHS; b++) begin : g_pair
            assert_level_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (v_q[a] && v_q[b] && closed_q[a] && closed_q[b] && grant_q[a] <= LVL_W'(LEVELS))
                |-> (grant_q[a] != grant_q[b]));
        end
    end

endmodule

// File: rtl/epoch_ooo_sched.sv
module epoch_ooo_sched #(
    parameter int NUM_EPOCHS = 2,   // power of two
    parameter int PT_DEPTH   = 64,  // power of two
    parameter int LEVELS     = 4,
    parameter int EID_W      = 6,
    localparam int PT_W      = $clog2(PT_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    output logic                alloc_ready,
    output logic [PT_W-1:0]     alloc_idx,
    output logic [EID_W-1:0]    alloc_eid,
    input  logic                fence_valid,
    output logic                fence_ready,
    input  logic                node_done_valid,
    input  logic [PT_W-1:0]     node_done_idx,
    output logic [PT_DEPTH-1:0] pt_go,
    output logic                persist_done_valid,
    output logic [PT_W-1:0]     persist_done_idx,
    output logic                epoch_done_valid,
    output logic [EID_W-1:0]    epoch_done_eid
);

    localparam int LVL_W  = $clog2(LEVELS + 2);
    localparam int EP_W   = (NUM_EPOCHS > 1) ? $clog2(NUM_EPOCHS) : 1;
    localparam int CNT_W  = $clog2(NUM_EPOCHS + 1);
    localparam int PCNT_W = $clog2(PT_DEPTH + 1);

    logic                             alloc_fire, step, any_closed, all_ready;
    logic [NUM_EPOCHS-1:0]            ep_valid, ep_has, ep_busy;
    logic [NUM_EPOCHS-1:0][PT_W-1:0]  ep_first, ep_last;
    logic [NUM_EPOCHS-1:0][LVL_W-1:0] ep_grant;

    eps_epoch_table #(
        .NUM_EPOCHS(NUM_EPOCHS), .PT_DEPTH(PT_DEPTH), .LEVELS(LEVELS), .EID_W(EID_W),
        .PT_W(PT_W), .LVL_W(LVL_W), .EP_W(EP_W), .CNT_W(CNT_W), .PCNT_W(PCNT_W)
    ) u_epochs (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .fence_valid(fence_valid), .step(step), .ep_busy(ep_busy),
        .alloc_ready(alloc_ready), .alloc_fire(alloc_fire), .alloc_idx(alloc_idx),
        .alloc_eid(alloc_eid), .fence_ready(fence_ready),
        .ep_valid(ep_valid), .ep_has(ep_has), .ep_first(ep_first), .ep_last(ep_last),
        .ep_grant(ep_grant), .any_closed(any_closed), .all_ready(all_ready),
        .epoch_done_valid(epoch_done_valid), .epoch_done_eid(epoch_done_eid)
    );

    eps_persist_table #(
        .NUM_EPOCHS(NUM_EPOCHS), .PT_DEPTH(PT_DEPTH), .LEVELS(LEVELS),
        .PT_W(PT_W), .LVL_W(LVL_W)
    ) u_persists (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .alloc_idx(alloc_idx),
        .done_valid(node_done_valid), .done_idx(node_done_idx),
        .ep_valid(ep_valid), .ep_has(ep_has), .ep_first(ep_first), .ep_last(ep_last),
        .ep_grant(ep_grant), .go(pt_go), .ep_busy(ep_busy),
        .persist_done_valid(persist_done_valid), .persist_done_idx(persist_done_idx)
    );

    eps_level_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .any_closed(any_closed), .all_ready(all_ready), .step(step)
    );

endmodule

// File: tb/test_epoch_ooo_sched.sv
module test_epoch_ooo_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, fence_valid = 1'b0, node_done_valid = 1'b0;
    logic [5:0]  node_done_idx = '0;
    logic        alloc_ready, fence_ready, persist_done_valid, epoch_done_valid;
    logic [5:0]  alloc_idx, alloc_eid, persist_done_idx, epoch_done_eid;
    logic [63:0] pt_go;

    int checks = 0, errors = 0;
    int ed_n = 0;
    logic [5:0] ed_log [16];
    int exp_tail = 0;

    always #5 clk = ~clk;

    epoch_ooo_sched i_epoch_ooo_sched (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .alloc_eid(alloc_eid), .fence_valid(fence_valid), .fence_ready(fence_ready),
        .node_done_valid(node_done_valid), .node_done_idx(node_done_idx), .pt_go(pt_go),
        .persist_done_valid(persist_done_valid), .persist_done_idx(persist_done_idx),
        .epoch_done_valid(epoch_done_valid), .epoch_done_eid(epoch_done_eid)
    );

    always @(negedge clk) begin
        if (epoch_done_valid && ed_n < 16) begin
            ed_log[ed_n] = epoch_done_eid;
            ed_n++;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] bit_of(input int i);
        return 64'd1 << i;
    endfunction

    task automatic alloc_one(input logic [5:0] exp_eid, input string req);
        @(negedge clk);
        check(alloc_ready == 1'b1, req, {63'd0, alloc_ready}, 64'd1);
        check(alloc_idx == 6'(exp_tail), req, {58'd0, alloc_idx}, 64'(exp_tail));
        check(alloc_eid == exp_eid, req, {58'd0, alloc_eid}, {58'd0, exp_eid});
        alloc_valid = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        exp_tail = (exp_tail + 1) % 64;
    endtask

    task automatic fence();
        @(negedge clk);
        fence_valid = 1'b1;
        @(negedge clk);
        fence_valid = 1'b0;
    endtask

    task automatic done(input int idx);
        @(negedge clk);
        node_done_valid = 1'b1;
        node_done_idx   = 6'(idx);
        @(negedge clk);
        node_done_valid = 1'b0;
    endtask

    task automatic wait_go(input logic [63:0] mask, input string req);
        for (int n = 0; n < 20 && pt_go != mask; n++) @(negedge clk);
        check(pt_go == mask, req, pt_go, mask);
    endtask

    task automatic wait_epochs(input int n_exp);
        for (int n = 0; n < 40 && ed_n < n_exp; n++) @(negedge clk);
    endtask

    task automatic t_reset();
        check(pt_go == 64'd0, "R1", pt_go, 64'd0);
        check(!persist_done_valid && !epoch_done_valid, "R1",
              {62'd0, persist_done_valid, epoch_done_valid}, 64'd0);
        check(alloc_ready && fence_ready, "R1", {62'd0, alloc_ready, fence_ready}, 64'd3);
    endtask

    // two persists in one epoch, finished out of order at every level
    task automatic t_single_epoch();
        logic [63:0] both;
        both = bit_of(0) | bit_of(1);
        alloc_one(6'd0, "R2");
        alloc_one(6'd0, "R2");
        repeat (4) @(negedge clk);
        check(pt_go == 64'd0, "R3 open epoch", pt_go, 64'd0);
        fence();
        wait_go(both, "R3 leaf grant");
        for (int lv = 4; lv >= 1; lv--) begin
            done(1);
            check(pt_go == bit_of(0), "R4", pt_go, bit_of(0));
            if (lv == 1) check(persist_done_valid && persist_done_idx == 6'd1, "R7",
                               {57'd0, persist_done_valid, persist_done_idx}, 64'h41);
            done(0);
            check(pt_go == 64'd0, "R5 stall", pt_go, 64'd0);
            if (lv == 1) check(persist_done_valid && persist_done_idx == 6'd0, "R7",
                               {57'd0, persist_done_valid, persist_done_idx}, 64'h40);
            else wait_go(both, "R5 next level");
        end
        wait_epochs(1);
        check(ed_n == 1 && ed_log[0] == 6'd0, "R8", 64'(ed_log[0]), 64'd0);
    endtask

    // two closed epochs pipelined one level apart
    task automatic t_pipelined();
        logic [63:0] pq, all3;
        pq   = bit_of(2) | bit_of(3);
        all3 = pq | bit_of(4);
        alloc_one(6'd1, "R2");
        alloc_one(6'd1, "R2");
        fence();
        alloc_one(6'd2, "R2 new epoch");
        fence();
        wait_go(pq, "R6 younger waits");
        repeat (3) @(negedge clk);
        check(pt_go == pq, "R6 still exclusive", pt_go, pq);
        check(!fence_ready && !alloc_ready, "R9 full", {62'd0, fence_ready, alloc_ready}, 64'd0);
        fence();
        done(2);
        done(3);
        wait_go(all3, "R6 pipelined");
        for (int r = 0; r < 2; r++) begin
            done(4);
            check(pt_go == pq, "R5 younger stalls", pt_go, pq);
            repeat (3) @(negedge clk);
            check(pt_go == pq, "R5 held", pt_go, pq);
            done(2);
            done(3);
            wait_go(all3, "R6 pipelined");
        end
        done(4);
        done(2);
        done(3);
        wait_go(bit_of(4), "R6 last level");
        done(4);
        check(persist_done_valid && persist_done_idx == 6'd4, "R7",
              {57'd0, persist_done_valid, persist_done_idx}, 64'h44);
        wait_epochs(3);
        check(ed_n == 3 && ed_log[1] == 6'd1 && ed_log[2] == 6'd2, "R8 order",
              {52'd0, ed_log[1], ed_log[2]}, 64'h042);
    endtask

    task automatic t_empty();
        @(negedge clk);
        check(alloc_eid == 6'd3, "R9 no number consumed", {58'd0, alloc_eid}, 64'd3);
        fence();
        wait_epochs(4);
        check(ed_n == 4 && ed_log[3] == 6'd3, "R10", 64'(ed_log[3]), 64'd3);
    endtask

    task automatic t_unauth();
        alloc_one(6'd4, "R2");
        done(5);
        check(!persist_done_valid && pt_go == 64'd0, "R11", pt_go, 64'd0);
        fence();
        for (int lv = 4; lv >= 1; lv--) begin
            wait_go(bit_of(5), "R11 climb");
            done(5);
            check(persist_done_valid == (lv == 1), "R11 level count",
                  {63'd0, persist_done_valid}, 64'(lv == 1));
        end
        wait_epochs(5);
        check(ed_n == 5 && ed_log[4] == 6'd4, "R8", 64'(ed_log[4]), 64'd4);
    endtask

    task automatic t_full();
        for (int i = 0; i < 64; i++) alloc_one(6'd5, "R2 wrap");
        @(negedge clk);
        check(!alloc_ready && fence_ready, "R12 full", {62'd0, alloc_ready, fence_ready}, 64'd1);
        alloc_valid = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        fence();
        wait_go({64{1'b1}}, "R12 all members");
        for (int lv = 4; lv >= 1; lv--) begin
            for (int i = 63; i >= 0; i--) done(i);
            if (lv > 1) wait_go({64{1'b1}}, "R12 next level");
        end
        wait_epochs(6);
        check(ed_n == 6 && ed_log[5] == 6'd5, "R12 retire", 64'(ed_log[5]), 64'd5);
        @(negedge clk);
        check(alloc_ready && alloc_idx == 6'd6, "R12 freed", {57'd0, alloc_ready, alloc_idx}, 64'h46);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_epoch();
        t_pipelined();
        t_empty();
        t_unauth();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule